// File: doc/BRIEF.md
# Programmable Clock Output Controller

This block produces one free-standing clock output for an external pin. The output is taken from a divider chain that runs on a reference clock at twice the oscillator rate. A single 8-bit control register sits behind a small bus port at one fixed address. It holds an enable bit and a 4-bit rate select. Software first writes the rate, then sets the enable bit in a separate masked write.

A mode input selects the system clock. When it is high, the system clock equals the oscillator. When it is low, the system clock is half the oscillator, which adds one halving to every rate. Each output is a registered copy of a divider bit. The enable only takes effect while the selected divider bit is low, so a high phase on the output is never cut short.

A sticky error flag reports three kinds of misuse: an illegal rate code, nonzero reserved bits, and a rate change attempted while the output is still running.

Top module: `clkout_ctrl`

## Requirements
- R1: After reset, the register reads 0x00, `clk_o` is low and `err_o` is low.
- R2: A read with `req_i` high, `we_i` low and `addr_i` = 0xFF40 returns the stored register on `rdata_o`. Any other address reads 0x00 and ignores writes. The layout is: bit 7 enable, bits 6:4 reserved, bits 3:0 rate select.
- R3: A write changes only the bits whose `wmask_i` bit is 1. Every other bit keeps its value.
- R4: With `full_rate_i` = 1 and legal select code c (5 to 12), `clk_o` has a period of 2^(c-4) reference cycles at 50 % duty.
- R5: With `full_rate_i` = 0, every legal code gives twice the period it gives in R4.
- R6: Select codes outside 5..12 are illegal. A write that touches bits 3:0 with an illegal result stores the code and sets `err_o`. While an illegal code is stored, `clk_o` stays low even if enabled.
- R7: Bits 6:4 always read zero. A write that puts a 1 into any of them sets `err_o`.
- R8: A write that would change the select while the enable bit is set, or while the output has not yet stopped, leaves the select unchanged and sets `err_o`. The other written bits still take effect.
- R9: Every high phase of `clk_o` lasts the full half period of the selected rate, including across enable and disable. Once the output has stopped after a disable, `clk_o` stays low.
- R10: `err_o` stays set until reset. Legal writes never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock at twice the oscillator rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Bus write (1) or read (0) |
| addr_i | input | 16 | Bus address |
| wdata_i | input | 8 | Write data |
| wmask_i | input | 8 | Per-bit write mask |
| rdata_o | output | 8 | Read data, zero when not reading the register |
| full_rate_i | input | 1 | 1: system clock equals oscillator; 0: half the oscillator |
| clk_o | output | 1 | Divided clock output |
| err_o | output | 1 | Sticky misuse flag |

## Verification
A fault in the divider counter or the tap selection shows up as a wrong high width or period on `clk_o` within one output period, which is at most 512 reference cycles. A fault in the enable latch shows up as a shortened first or last high phase, or as activity after a disable, within one half period of the enable write. Faults in the register or the error logic appear on `rdata_o` or `err_o` on the access right after the offending write.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  typedef struct packed {
    logic       en;
    logic [2:0] rsv;
    logic [3:0] sel;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/clkout_regs.sv
module clkout_regs
  import clkout_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 16'hFF40,
  parameter int unsigned       CODE_BASE = 5,
  parameter int unsigned       NUM_SEL   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic [CTRL_W-1:0] wmask_i,
  input  logic              running_i,
  output logic [CTRL_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic              code_ok_o,
  output logic              err_o
);
  localparam int unsigned CODE_LAST = CODE_BASE + NUM_SEL - 1;

  function automatic logic code_valid(input logic [3:0] s);
    return (32'(s) >= CODE_BASE) && (32'(s) <= CODE_LAST);
  endfunction

  ctrl_t             ctrl_q, nxt;
  logic              err_q;
  logic              hit, wr;
  logic [CTRL_W-1:0] merged_raw;
  ctrl_t             merged;
  logic              sel_chg, sel_blk, rsv_bad, code_bad;

  always_comb begin
    hit        = req_i && (addr_i == REG_ADDR);
    wr         = hit && we_i;
    merged_raw = (ctrl_q & ~wmask_i) | (wdata_i & wmask_i);
    merged     = ctrl_t'(merged_raw);
    sel_chg    = merged.sel != ctrl_q.sel;
    // rate change refused until the output has fully stopped
    sel_blk    = sel_chg && (ctrl_q.en || running_i);
    rsv_bad    = |merged.rsv;
    code_bad   = (|wmask_i[3:0]) && !sel_blk && !code_valid(merged.sel);
    nxt.en     = merged.en;
    nxt.rsv    = '0;
    nxt.sel    = sel_blk ? ctrl_q.sel : merged.sel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      err_q  <= 1'b0;
    end else if (wr) begin
      ctrl_q <= nxt;
      if (rsv_bad || sel_blk || code_bad) err_q <= 1'b1;
    end
  end

  assign rdata_o   = (hit && !we_i) ? ctrl_q : '0;
  assign ctrl_o    = ctrl_q;
  assign code_ok_o = code_valid(ctrl_q.sel);
  assign err_o     = err_q;
endmodule

// File: rtl/clkout_div.sv
module clkout_div #(
  parameter int unsigned CODE_BASE = 5,
  parameter int unsigned NUM_SEL   = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] sel_i,
  input  logic       full_rate_i,
  output logic       tap_o
);
  localparam int unsigned CNT_W = NUM_SEL + 1;
  localparam int unsigned IDX_W = $clog2(CNT_W);
  localparam int unsigned TAP_N = 2 ** IDX_W;

  logic [CNT_W-1:0] cnt_q;
  logic [TAP_N-1:0] taps;
  logic [7:0]       idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(1);
  end

  for (genvar i = 0; i < TAP_N; i++) begin : g_tap
    if (i < CNT_W) begin : g_live
      assign taps[i] = cnt_q[i];
    end else begin : g_pad
      assign taps[i] = 1'b0;
    end
  end

  always_comb begin
    // half-rate system clock adds one stage
    idx   = 8'(sel_i) - 8'(CODE_BASE) + {7'd0, ~full_rate_i};
    tap_o = (idx < 8'(CNT_W)) && taps[idx[IDX_W-1:0]];
  end
endmodule

// File: rtl/clkout_gate.sv
module clkout_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ok_i,
  input  logic tap_i,
  output logic run_o,
  output logic clk_o
);
  logic run_q, out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      out_q <= 1'b0;
    end else begin
      // run state only moves while the selected tap is low
      if (!tap_i) run_q <= en_i && ok_i;
      out_q <= run_q && ok_i && tap_i;
    end
  end

  assign run_o = run_q;
  assign clk_o = out_q;
endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
  import clkout_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 16'hFF40,
  parameter int unsigned       CODE_BASE = 5,
  parameter int unsigned       NUM_SEL   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [7:0]        wmask_i,
  output logic [7:0]        rdata_o,
  input  logic              full_rate_i,
  output logic              clk_o,
  output logic              err_o
);
  ctrl_t ctrl;
  logic  code_ok, run, tap;

  clkout_regs #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR),
    .CODE_BASE(CODE_BASE),
    .NUM_SEL  (NUM_SEL)
  ) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .wmask_i  (wmask_i),
    .running_i(run),
    .rdata_o  (rdata_o),
    .ctrl_o   (ctrl),
    .code_ok_o(code_ok),
    .err_o    (err_o)
  );

  clkout_div #(
    .CODE_BASE(CODE_BASE),
    .NUM_SEL  (NUM_SEL)
  ) i_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (ctrl.sel),
    .full_rate_i(full_rate_i),
    .tap_o      (tap)
  );

  clkout_gate i_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ctrl.en),
    .ok_i  (code_ok),
    .tap_i (tap),
    .run_o (run),
    .clk_o (clk_o)
  );
endmodule

// File: rtl/clkout_ctrl_chk.sv
module clkout_ctrl_chk #(
  parameter int unsigned       ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFF40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wmask_i,
  input logic [7:0]        rdata_o,
  input logic              clk_o,
  input logic              err_o,
  input logic              run_i,
  input logic              code_ok_i,
  input logic [3:0]        sel_i
);
  assert_rsv_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[6:4] == 3'b000);

  assert_sel_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == REG_ADDR && |wmask_i[3:0] && run_i) |=> $stable(sel_i));

  assert_bad_code_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !code_ok_i |=> !clk_o);

  assert_stopped_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !clk_o);

  assert_stop_on_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(run_i) |-> !clk_o);

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind clkout_ctrl clkout_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .REG_ADDR(REG_ADDR)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wmask_i  (wmask_i),
  .rdata_o  (rdata_o),
  .clk_o    (clk_o),
  .err_o    (err_o),
  .run_i    (run),
  .code_ok_i(code_ok),
  .sel_i    (ctrl.sel)
);

// File: tb/test_clkout_ctrl.sv
module test_clkout_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] REG = 16'hFF40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, wmask = '0, rdata;
  logic        full_rate = 1'b1;
  logic        clk_out, err;

  int n_chk = 0, n_fail = 0;
  int exp_half = 1;
  bit mon_on = 0;
  int hi = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  clkout_ctrl i_clkout_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .wmask_i(wmask), .rdata_o(rdata),
    .full_rate_i(full_rate), .clk_o(clk_out), .err_o(err)
  );

  task automatic check_eq(input string req_tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic [7:0] m);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; wmask = m;
    @(negedge clk);
    req = 0; we = 0; wmask = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    req = 0;
  endtask

  task automatic do_reset();
    mon_on = 0;
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic count_high(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (clk_out) n++;
    end
  endtask

  task automatic meas_period(input string req_tag, input int half);
    int c;
    bit prev;
    do @(negedge clk); while (clk_out !== 1'b0);
    do @(negedge clk); while (clk_out !== 1'b1);
    c = 0;
    prev = 1;
    forever begin
      @(negedge clk);
      c++;
      if (clk_out && !prev) break;
      prev = clk_out;
    end
    check_eq(req_tag, "output period", c, 2 * half);
  endtask

  // high pulse widths, checked whenever enabled (R9)
  initial begin
    forever begin
      @(negedge clk);
      if (clk_out) hi++;
      else begin
        if (hi > 0 && mon_on) check_eq("R9", "high phase width", hi, exp_half);
        hi = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;

    // R1 reset state
    do_reset();
    rd(REG, d);
    check_eq("R1", "reset value", d, 8'h00);
    count_high(20, n);
    check_eq("R1", "output idle after reset", n, 0);
    check_eq("R1", "error after reset", err, 0);

    // R2 address decode
    wr(16'hFF41, 8'h85, 8'hFF);
    rd(REG, d);
    check_eq("R2", "foreign write ignored", d, 8'h00);
    wr(REG, 8'h07, 8'h0F);
    rd(16'hFF41, d);
    check_eq("R2", "foreign read zero", d, 8'h00);
    rd(REG, d);
    check_eq("R2", "readback", d, 8'h07);

    // R3 masked writes
    wr(REG, 8'hFF, 8'h00);
    rd(REG, d);
    check_eq("R3", "empty mask", d, 8'h07);
    wr(REG, 8'h85, 8'h80);
    rd(REG, d);
    check_eq("R3", "enable-only write", d, 8'h87);
    check_eq("R10", "legal writes leave error low", err, 0);
    wr(REG, 8'h00, 8'h80);
    repeat (20) @(negedge clk);

    // R4 / R5 sweep all codes in both modes
    for (int mode = 1; mode >= 0; mode--) begin
      full_rate = mode[0];
      for (int code = 5; code <= 12; code++) begin
        string tag;
        tag = mode ? "R4" : "R5";
        exp_half = 1 << (code - 5 + (mode ? 0 : 1));
        wr(REG, 8'(code), 8'h0F);
        wr(REG, 8'h80, 8'h80);
        mon_on = 1;
        rd(REG, d);
        check_eq("R2", "enabled readback", d, 8'h80 | code);
        meas_period(tag, exp_half);
        meas_period(tag, exp_half);
        wr(REG, 8'h00, 8'h80);
        repeat (2 * exp_half + 4) @(negedge clk);
        count_high(2 * exp_half + 2, n);
        check_eq("R9", "silent after disable", n, 0);
      end
    end
    check_eq("R10", "no error after legal sweep", err, 0);
    full_rate = 1;

    // R6 illegal codes, exhaustive
    for (int code = 0; code < 16; code++) begin
      if (code >= 5 && code <= 12) continue;
      do_reset();
      wr(REG, 8'(code), 8'h0F);
      check_eq("R6", "illegal code flags error", err, 1);
      rd(REG, d);
      check_eq("R6", "illegal code stored", d, code);
    end
    wr(REG, 8'h80, 8'h80);
    count_high(600, n);
    check_eq("R6", "illegal code keeps output low", n, 0);

    // R7 reserved bits
    do_reset();
    wr(REG, 8'h75, 8'hFF);
    check_eq("R7", "reserved write flags error", err, 1);
    rd(REG, d);
    check_eq("R7", "reserved bits read zero", d, 8'h05);

    // R8 select change while running
    do_reset();
    exp_half = 1;
    wr(REG, 8'h05, 8'h0F);
    wr(REG, 8'h80, 8'h80);
    mon_on = 1;
    repeat (10) @(negedge clk);
    check_eq("R8", "no error before change", err, 0);
    wr(REG, 8'h06, 8'h0F);
    check_eq("R8", "blocked change flags error", err, 1);
    rd(REG, d);
    check_eq("R8", "select unchanged", d, 8'h85);
    meas_period("R8", 1);

    // R10 stickiness
    wr(REG, 8'h00, 8'h80);
    repeat (50) @(negedge clk);
    wr(REG, 8'h07, 8'h0F);
    check_eq("R10", "error stays set", err, 1);
    do_reset();
    check_eq("R10", "reset clears error", err, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule